// File: doc/BRIEF.md
# Indirect Register and Memory Access Port

This block puts two internal targets behind a narrow 16-bit host register window. The targets are a 16-bit control-register file and a 24-bit memory. Each target has its own pair of host registers. A pointer register holds the word address, a direction bit and, for the memory, a width bit. A data register carries the value. The host never addresses a target directly. It loads a pointer, and it moves data through the data register. The block runs the transfer on a simple request/acknowledge port on the internal side.

A host write to a pointer register with the direction bit cleared starts a fetch. The fetched word lands in the matching data register. With the direction bit set, a write to the data register commits the value to the target. The 24-bit memory data is shown to the host as two offsets: a low 16-bit half and an upper 8-bit half. A memory write fires when the host writes the low half. In 16-bit mode a read clears the upper half, and a write leaves the upper byte of the memory word as it was.

Each target is sequenced by its own transfer engine. The engine has three states. Idle goes to Access on a launch. Access asserts the request and goes to Retire when the acknowledge arrives. Retire delivers the fetched data and returns to Idle unconditionally. Busy is reported in the pointer register for every state other than Idle.

Top module: `iop_indirect_port`

## Requirements
- R1: After reset, every host offset reads 0, and neither internal request is asserted.
- R2: Writing offset 0 with bit 15 = 0 starts one control read of the pointer in bits [CTRL_AW-1:0]. Bit 13 of offset 0 reads 1 from the cycle after that write until the word is loaded into offset 1.
- R3: Writing offset 1 while the control direction bit (offset 0 bit 15) is 1 issues one control write of that value. With the direction bit 0, the value is only stored in offset 1, and no request is issued.
- R4: Writing a pointer register (offset 0 or offset 2) with bit 15 = 1 issues no internal request.
- R5: Writing offset 2 with bit 15 = 0 and bit 14 = 1 (24-bit mode) reads one memory word. Bits [15:0] of the word go to offset 3. Bits [23:16] go to bits [7:0] of offset 4, and bits [15:8] of offset 4 read 0.
- R6: A memory read with bit 14 = 0 (16-bit mode) loads offset 3 and clears offset 4 to 0.
- R7: With offset 2 bit 15 = 1, a write to offset 3 writes the memory word at the pointer in bits [MEM_AW-1:0]. In 24-bit mode the word is {offset 4, offset 3}. In 16-bit mode only the low 16 bits change. A write to offset 4 alone issues no request.
- R8: While a pair is busy, host writes to that pair's pointer and data offsets have no effect.
- R9: An internal request stays asserted, with stable address, data and direction, until it is acknowledged. It drops in the cycle after the acknowledge, so each launch gives exactly one transfer.
- R10: Offsets 5 to 7 read 0, and writes to them change nothing.
- R11: The control pair and the memory pair work independently. A control transfer completes while a memory transfer is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_ofs | input | 3 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the register at host_ofs |
| creg_req | output | 1 | Control-register request |
| creg_we | output | 1 | Control-register write direction |
| creg_addr | output | CTRL_AW | Control-register word pointer |
| creg_wdata | output | 16 | Control-register write data |
| creg_rdata | input | 16 | Control-register read data |
| creg_ack | input | 1 | Control-register acknowledge |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write direction |
| mem_hi_we | output | 1 | Memory upper-byte write enable |
| mem_addr | output | MEM_AW | Memory word pointer |
| mem_wdata | output | MEM_DW | Memory write data |
| mem_rdata | input | MEM_DW | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The assertions check these behaviours on every cycle:
- the request handshake: a request is held until its acknowledge, the address and data stay stable while it waits, and there is one beat per launch;
- the pointer registers stay frozen while their pair is busy;
- the upper data half is filled or cleared correctly according to the width bit.

Only the bench's scenarios can show the rest:
- the offset decode and the field positions;
- that each launch condition fires only for the right direction;
- that a 16-bit write preserves the memory's upper byte;
- that the two pairs stay independent while one is stalled by a withheld acknowledge.

// File: rtl/iop_pkg.sv
package iop_pkg;
    localparam int HOST_DW = 16;

    localparam logic [2:0] OFS_CPTR = 3'd0;
    localparam logic [2:0] OFS_CDAT = 3'd1;
    localparam logic [2:0] OFS_MPTR = 3'd2;
    localparam logic [2:0] OFS_MLO  = 3'd3;
    localparam logic [2:0] OFS_MHI  = 3'd4;

    localparam int BIT_DIR  = 15;
    localparam int BIT_WIDE = 14;
    localparam int BIT_BUSY = 13;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_ACCESS = 2'd1,
        XF_RETIRE = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/iop_xfer_fsm.sv
module iop_xfer_fsm
    import iop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          launch_we,
    output logic          port_req,
    output logic          port_we,
    input  logic          port_ack,
    input  logic [DW-1:0] port_rdata,
    output logic          busy,
    output logic          rd_fill,
    output logic [DW-1:0] result
);
    xfer_state_e state, state_n;
    logic          we_q;
    logic [DW-1:0] result_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= XF_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            XF_IDLE:   if (launch)   state_n = XF_ACCESS;
            XF_ACCESS: if (port_ack) state_n = XF_RETIRE;
            XF_RETIRE: state_n = XF_IDLE;
            default:   state_n = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            result_q <= '0;
        end else begin
            if (state == XF_IDLE && launch) we_q <= launch_we;
            if (state == XF_ACCESS && port_ack && !we_q) result_q <= port_rdata;
        end
    end

    always_comb begin
        port_req = (state == XF_ACCESS);
        port_we  = we_q;
        busy     = (state != XF_IDLE);
        rd_fill  = (state == XF_RETIRE) && !we_q;
        result   = result_q;
    end

    // R9: request held until acknowledged
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        port_req && !port_ack |=> port_req);
    // R9: one beat per launch
    a_r9_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        port_req && port_ack |=> !port_req);
    // R9: direction stable during request
    a_r9_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        port_req && $past(port_req) |-> $stable(port_we));
endmodule

// File: rtl/iop_reg_bank.sv
module iop_reg_bank
    import iop_pkg::*;
#(
    parameter int CTRL_AW = 8,
    parameter int MEM_AW  = 12,
    parameter int MEM_DW  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_we,
    input  logic [2:0]         host_ofs,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               c_busy,
    input  logic               c_fill,
    input  logic [HOST_DW-1:0] c_result,
    input  logic               m_busy,
    input  logic               m_fill,
    input  logic [MEM_DW-1:0]  m_result,
    output logic               c_launch,
    output logic               c_launch_we,
    output logic [CTRL_AW-1:0] c_ptr,
    output logic [HOST_DW-1:0] c_wdata,
    output logic               m_launch,
    output logic               m_launch_we,
    output logic [MEM_AW-1:0]  m_ptr,
    output logic [MEM_DW-1:0]  m_wdata,
    output logic               m_wide
);
    localparam int HI_W = MEM_DW - HOST_DW;

    logic               c_dir, m_dir;
    logic [HOST_DW-1:0] c_data, m_lo;
    logic [HI_W-1:0]    m_hi;
    logic wr_cptr, wr_cdat, wr_mptr, wr_mlo, wr_mhi;

    always_comb begin
        wr_cptr = host_sel && host_we && host_ofs == OFS_CPTR && !c_busy;
        wr_cdat = host_sel && host_we && host_ofs == OFS_CDAT && !c_busy;
        wr_mptr = host_sel && host_we && host_ofs == OFS_MPTR && !m_busy;
        wr_mlo  = host_sel && host_we && host_ofs == OFS_MLO  && !m_busy;
        wr_mhi  = host_sel && host_we && host_ofs == OFS_MHI  && !m_busy;
        c_launch    = (wr_cptr && !host_wdata[BIT_DIR]) || (wr_cdat && c_dir);
        c_launch_we = wr_cdat;
        m_launch    = (wr_mptr && !host_wdata[BIT_DIR]) || (wr_mlo && m_dir);
        m_launch_we = wr_mlo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_dir  <= 1'b0;
            c_ptr  <= '0;
            c_data <= '0;
        end else begin
            if (wr_cptr) begin
                c_dir <= host_wdata[BIT_DIR];
                c_ptr <= host_wdata[CTRL_AW-1:0];
            end
            if (wr_cdat)     c_data <= host_wdata;
            else if (c_fill) c_data <= c_result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_dir  <= 1'b0;
            m_wide <= 1'b0;
            m_ptr  <= '0;
            m_lo   <= '0;
            m_hi   <= '0;
        end else begin
            if (wr_mptr) begin
                m_dir  <= host_wdata[BIT_DIR];
                m_wide <= host_wdata[BIT_WIDE];
                m_ptr  <= host_wdata[MEM_AW-1:0];
            end
            if (wr_mlo)      m_lo <= host_wdata;
            else if (m_fill) m_lo <= m_result[HOST_DW-1:0];
            if (wr_mhi)      m_hi <= host_wdata[HI_W-1:0];
            else if (m_fill) m_hi <= m_wide ? m_result[MEM_DW-1:HOST_DW] : '0;
        end
    end

    always_comb begin
        c_wdata = c_data;
        m_wdata = {m_hi, m_lo};
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_ofs)
            OFS_CPTR: begin
                host_rdata[BIT_DIR]     = c_dir;
                host_rdata[BIT_BUSY]    = c_busy;
                host_rdata[CTRL_AW-1:0] = c_ptr;
            end
            OFS_CDAT: host_rdata = c_data;
            OFS_MPTR: begin
                host_rdata[BIT_DIR]    = m_dir;
                host_rdata[BIT_WIDE]   = m_wide;
                host_rdata[BIT_BUSY]   = m_busy;
                host_rdata[MEM_AW-1:0] = m_ptr;
            end
            OFS_MLO: host_rdata = m_lo;
            OFS_MHI: host_rdata[HI_W-1:0] = m_hi;
            default: host_rdata = '0;
        endcase
    end

    // R8: pointer fields frozen while busy
    a_r8_cptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        c_busy && $past(c_busy) |-> $stable(c_ptr) && $stable(c_dir));
    a_r8_mptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        m_busy && $past(m_busy) |-> $stable(m_ptr) && $stable(m_wide) && $stable(m_dir));
    // R6: narrow read clears upper half
    a_r6_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        m_fill && !m_wide |=> m_hi == '0);
    // R5: wide read fills upper half from the word
    a_r5_wide_hi_fill: assert property (@(posedge clk) disable iff (!rst_n)
        m_fill && m_wide |=> m_hi == $past(m_result[MEM_DW-1:HOST_DW]));
endmodule

// File: rtl/iop_indirect_port.sv
module iop_indirect_port
    import iop_pkg::*;
#(
    parameter int CTRL_AW = 8,
    parameter int MEM_AW  = 12,
    parameter int MEM_DW  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_we,
    input  logic [2:0]         host_ofs,
    input  logic [15:0]        host_wdata,
    output logic [15:0]        host_rdata,
    output logic               creg_req,
    output logic               creg_we,
    output logic [CTRL_AW-1:0] creg_addr,
    output logic [15:0]        creg_wdata,
    input  logic [15:0]        creg_rdata,
    input  logic               creg_ack,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_hi_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [MEM_DW-1:0]  mem_wdata,
    input  logic [MEM_DW-1:0]  mem_rdata,
    input  logic               mem_ack
);
    logic               c_launch, c_launch_we, c_busy, c_fill;
    logic [15:0]        c_result;
    logic               m_launch, m_launch_we, m_busy, m_fill, m_wide;
    logic [MEM_DW-1:0]  m_result;

    iop_reg_bank #(.CTRL_AW(CTRL_AW), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_ofs(host_ofs),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .c_busy(c_busy), .c_fill(c_fill), .c_result(c_result),
        .m_busy(m_busy), .m_fill(m_fill), .m_result(m_result),
        .c_launch(c_launch), .c_launch_we(c_launch_we),
        .c_ptr(creg_addr), .c_wdata(creg_wdata),
        .m_launch(m_launch), .m_launch_we(m_launch_we),
        .m_ptr(mem_addr), .m_wdata(mem_wdata), .m_wide(m_wide)
    );

    iop_xfer_fsm #(.DW(16)) u_ceng (
        .clk(clk), .rst_n(rst_n),
        .launch(c_launch), .launch_we(c_launch_we),
        .port_req(creg_req), .port_we(creg_we),
        .port_ack(creg_ack), .port_rdata(creg_rdata),
        .busy(c_busy), .rd_fill(c_fill), .result(c_result)
    );

    iop_xfer_fsm #(.DW(MEM_DW)) u_meng (
        .clk(clk), .rst_n(rst_n),
        .launch(m_launch), .launch_we(m_launch_we),
        .port_req(mem_req), .port_we(mem_we),
        .port_ack(mem_ack), .port_rdata(mem_rdata),
        .busy(m_busy), .rd_fill(m_fill), .result(m_result)
    );

    assign mem_hi_we = mem_we && m_wide;

    // R9: memory address and data stable while waiting
    a_r9_mem_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> $stable(mem_addr) && $stable(mem_wdata));
    a_r9_creg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        creg_req && $past(creg_req) |-> $stable(creg_addr) && $stable(creg_wdata));
    // R7: upper byte never enabled on a read
    a_r7_no_hi_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> !mem_hi_we);
endmodule

// File: tb/sim_iop_indirect_port.sv
`timescale 1ns/1ps
module sim_iop_indirect_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        host_sel = 0, host_we = 0;
    logic [2:0]  host_ofs = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic        creg_req, creg_we, creg_ack;
    logic [7:0]  creg_addr;
    logic [15:0] creg_wdata, creg_rdata;
    logic        mem_req, mem_we, mem_hi_we, mem_ack;
    logic [11:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;
    logic        ack_en = 1'b1;

    logic [15:0] creg_m [0:63];
    logic [23:0] mem_m  [0:63];
    int creg_cnt = 0, mem_cnt = 0;
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    iop_indirect_port u0 (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_ofs(host_ofs),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .creg_req(creg_req), .creg_we(creg_we), .creg_addr(creg_addr),
        .creg_wdata(creg_wdata), .creg_rdata(creg_rdata), .creg_ack(creg_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_hi_we(mem_hi_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    assign creg_ack   = creg_req;
    assign creg_rdata = creg_m[creg_addr[5:0]];
    assign mem_ack    = mem_req && ack_en;
    assign mem_rdata  = mem_m[mem_addr[5:0]];

    always @(posedge clk) begin
        if (creg_req && creg_ack) begin
            creg_cnt <= creg_cnt + 1;
            if (creg_we) creg_m[creg_addr[5:0]] <= creg_wdata;
        end
        if (mem_req && mem_ack) begin
            mem_cnt <= mem_cnt + 1;
            if (mem_we) begin
                if (mem_hi_we) mem_m[mem_addr[5:0]] <= mem_wdata;
                else mem_m[mem_addr[5:0]][15:0] <= mem_wdata[15:0];
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [2:0] ofs, logic [15:0] d);
        @(negedge clk);
        host_sel = 1; host_we = 1; host_ofs = ofs; host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_we = 0;
    endtask

    task automatic hread(logic [2:0] ofs, output logic [15:0] d);
        host_ofs = ofs;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(logic [2:0] ofs);
        logic [15:0] v;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            hread(ofs, v);
            if (!v[13]) break;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int o = 0; o < 5; o++) begin
            hread(3'(o), v);
            check("R1 reset offset", {16'h0, v}, 32'h0);
        end
        check("R1 reqs idle", {30'h0, creg_req, mem_req}, 32'h0);
    endtask

    task automatic t_ctrl_read();
        logic [15:0] v;
        int c0 = creg_cnt;
        hwrite(3'd0, 16'h0012);
        hread(3'd0, v);
        check("R2 busy set", {16'h0, v}, 32'h2012);
        wait_idle(3'd0);
        hread(3'd1, v);
        check("R2 data fetched", {16'h0, v}, {16'h0, creg_m[6'h12]});
        hread(3'd0, v);
        check("R2 busy clear", {16'h0, v}, 32'h0012);
        check("R2 one request", creg_cnt - c0, 1);
    endtask

    task automatic t_ctrl_write();
        logic [15:0] v;
        int c0 = creg_cnt;
        hwrite(3'd0, 16'h8005);
        repeat (3) @(negedge clk);
        check("R4 no req on write-dir pointer", creg_cnt - c0, 0);
        hwrite(3'd1, 16'h5A5A);
        wait_idle(3'd0);
        check("R3 committed", {16'h0, creg_m[5]}, 32'h5A5A);
        check("R3 one write", creg_cnt - c0, 1);
        hwrite(3'd0, 16'h0007);
        wait_idle(3'd0);
        c0 = creg_cnt;
        hwrite(3'd1, 16'h1234);
        repeat (3) @(negedge clk);
        check("R3 read-dir data no req", creg_cnt - c0, 0);
        hread(3'd1, v);
        check("R3 read-dir data stored", {16'h0, v}, 32'h1234);
    endtask

    task automatic t_mem_read_wide();
        logic [15:0] v;
        int c0 = mem_cnt;
        hwrite(3'd2, 16'h4021);
        wait_idle(3'd2);
        hread(3'd3, v);
        check("R5 low half", {16'h0, v}, {16'h0, mem_m[6'h21][15:0]});
        hread(3'd4, v);
        check("R5 upper half", {16'h0, v}, {24'h0, mem_m[6'h21][23:16]});
        check("R5 one request", mem_cnt - c0, 1);
    endtask

    task automatic t_mem_read_narrow();
        logic [15:0] v;
        hwrite(3'd2, 16'h0022);
        wait_idle(3'd2);
        hread(3'd3, v);
        check("R6 low half", {16'h0, v}, {16'h0, mem_m[6'h22][15:0]});
        hread(3'd4, v);
        check("R6 upper cleared", {16'h0, v}, 32'h0);
    endtask

    task automatic t_mem_write();
        logic [23:0] old;
        int c0;
        hwrite(3'd2, 16'hC030);
        c0 = mem_cnt;
        hwrite(3'd4, 16'h00AB);
        repeat (3) @(negedge clk);
        check("R7 upper write no req", mem_cnt - c0, 0);
        hwrite(3'd3, 16'h1357);
        wait_idle(3'd2);
        check("R7 wide write", {8'h0, mem_m[6'h30]}, 32'hAB1357);
        hwrite(3'd2, 16'h8031);
        old = mem_m[6'h31];
        hwrite(3'd4, 16'h00EE);
        hwrite(3'd3, 16'h2468);
        wait_idle(3'd2);
        check("R7 narrow keeps upper byte", {8'h0, mem_m[6'h31]}, {8'h0, old[23:16], 16'h2468});
        hwrite(3'd2, 16'h8032);
        repeat (3) @(negedge clk);
        check("R4 mem pointer write-dir no req", mem_cnt - c0, 2);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        int c0 = mem_cnt;
        ack_en = 0;
        hwrite(3'd2, 16'h4010);
        repeat (3) @(negedge clk);
        check("R9 request held", {31'h0, mem_req}, 32'h1);
        hwrite(3'd2, 16'h4011);
        hwrite(3'd3, 16'hFFFF);
        hread(3'd2, v);
        check("R8 pointer unchanged while busy", {16'h0, v}, 32'h6010);
        check("R9 no beat while stalled", mem_cnt - c0, 0);
        ack_en = 1;
        wait_idle(3'd2);
        hread(3'd3, v);
        check("R8 data write ignored", {16'h0, v}, {16'h0, mem_m[6'h10][15:0]});
        check("R9 exactly one beat", mem_cnt - c0, 1);
    endtask

    task automatic t_concurrent();
        logic [15:0] v;
        ack_en = 0;
        hwrite(3'd2, 16'h0005);
        hwrite(3'd0, 16'h0009);
        wait_idle(3'd0);
        hread(3'd1, v);
        check("R11 ctrl done during mem stall", {16'h0, v}, {16'h0, creg_m[9]});
        hread(3'd2, v);
        check("R11 mem still busy", {31'h0, v[13]}, 32'h1);
        ack_en = 1;
        wait_idle(3'd2);
        hread(3'd3, v);
        check("R11 mem completes", {16'h0, v}, {16'h0, mem_m[5][15:0]});
    endtask

    task automatic t_unused();
        logic [15:0] v, p0;
        int c0 = creg_cnt, m0 = mem_cnt;
        hread(3'd0, p0);
        for (int o = 5; o < 8; o++) hwrite(3'(o), 16'hFFFF);
        for (int o = 5; o < 8; o++) begin
            hread(3'(o), v);
            check("R10 unused reads zero", {16'h0, v}, 32'h0);
        end
        hread(3'd0, v);
        check("R10 no side effect", {16'h0, v}, {16'h0, p0});
        check("R10 no requests", (creg_cnt - c0) + (mem_cnt - m0), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            creg_m[i] = 16'hA000 + 16'(i * 3);
            mem_m[i]  = 24'hC00000 ^ 24'(i * 24'h010203);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ctrl_read();
        t_ctrl_write();
        t_mem_read_wide();
        t_mem_read_narrow();
        t_mem_write();
        t_busy_ignore();
        t_concurrent();
        t_unused();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule